// File: doc/BRIEF.md
# Time-Snapshot Register File with Auto-Incrementing Pointer

This block is the byte-level register front end of a serial-bus real-time-clock slave. A bus controller, which handles the bit-level signalling, gives it one-cycle strobes: start of a write transfer, start of a read transfer, a written data byte and a read request. The block keeps a 64-entry byte space. Entries 0 to 6 are a latched copy of the live clock fields. Entry 7 is a control byte. Entries 8 to 63 are plain storage. A 6-bit pointer selects the entry for the current transfer and moves on after each data byte.

Reads always come from the latched copy, never from the live counters, so a multi-byte read returns one consistent time value. The copy is refreshed when a read transfer starts and each time the pointer rolls over. Writes to the clock entries are not stored locally. They are sent out on a load port to the running clock, which takes them into its counters. The control byte has reserved bits that always read as zero. It also has an oscillator-stop flag: software can clear this flag, but only the stop-detect input can set it.

Top module: `tsnap_regfile`

## Requirements
- R1: The byte space has 64 entries selected by a 6-bit pointer. Entries 0–6 are the time copy, entry 7 is control, and a data byte written at entries 8–63 is stored and read back unchanged.
- R2: After a start-of-write strobe, the first `wrEn` byte loads the pointer with `wrData[5:0]` and is not stored anywhere. Later bytes of the transfer are data.
- R3: Each data byte written and each byte read moves the pointer up by one. From 63 it goes to 0.
- R4: The seven copy entries load `timeNow` (entry i takes bits 8i+7..8i) at the clock edge where a start-of-read is accepted. They load again at the edge where a data access moves the pointer from 63 to 0.
- R5: A data write at entries 0–6 drives `timeLoadEn` high in the same cycle, with `timeLoadIdx` equal to the pointer and `timeLoadData` equal to `wrData`. The copy entry itself keeps its value.
- R6: A data write at entry 7 stores `wrData & 8'hB3`. Bits 6, 3 and 2 of the control byte therefore always read 0.
- R7: Control bit 5 is the oscillator-stop flag. Writing 0 clears it and writing 1 leaves it as it was. A high `oscStopEvt` sets it at the next edge, even when a clearing write happens in the same cycle.
- R8: While `rstN` is low, all 64 entries and the pointer are cleared and the address phase is ended.
- R9: `rdData` shows the entry at the pointer combinationally, so it is valid in the same cycle as `rdEn`. The pointer moves at the following edge.
- R10: When strobes coincide, only one is acted on, in the priority order startRd, startWr, wrEn, rdEn. The others in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| startWr | input | 1 | A write transfer begins; the next written byte is the pointer |
| startRd | input | 1 | A read transfer begins; refreshes the time copy |
| wrEn | input | 1 | One written byte is present on wrData |
| wrData | input | 8 | Written byte |
| rdEn | input | 1 | One byte is being read from rdData |
| rdData | output | 8 | Entry at the pointer, combinational |
| timeNow | input | 56 | Live clock fields, entry i in bits 8i+7..8i |
| oscStopEvt | input | 1 | One-cycle oscillator-stop detect pulse |
| timeLoadEn | output | 1 | A clock field is being written |
| timeLoadIdx | output | 3 | Which clock field (0–6) |
| timeLoadData | output | 8 | New value for that field |

## Verification
`rdData` and the three load-port outputs are combinational, so they are due in the same cycle as the strobe that selects them. Every other effect (pointer movement, stored bytes, time copy, control flag) is due one edge later. The bench drives each stimulus 1 ns after a rising edge and compares the combinational outputs 1 ns later, before the next edge. It then moves its behavioural model forward at that edge, so any registered effect appears in the comparison of the following cycle. A sweep with random stimulus applies the same per-cycle comparison to coinciding strobes, wraps and flag events.

// File: rtl/tsnap_pkg.sv
package tsnap_pkg;

  // One cycle's decoded work for the datapath.
  typedef struct packed {
    logic capture;    // reload time copy from live clock
    logic storeRam;   // write data byte into general storage
    logic storeCtrl;  // write data byte into control entry
    logic loadTime;   // forward data byte to the running clock
  } dpCmd_t;

endpackage

// File: rtl/tsnap_ctrl.sv
module tsnap_ctrl
  import tsnap_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SNAP_BYTES = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startRd,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] wrPtrBits,
  output dpCmd_t            cmd,
  output logic [ADDR_W-1:0] ptrQ,
  output logic              addrPhaseQ
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(SNAP_BYTES);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic acceptRd, acceptWrStart, acceptWr, acceptRead;
  logic addrByte, dataByte, advance, wrapHit;

  // Fixed priority: startRd > startWr > wrEn > rdEn.
  always_comb begin
    acceptRd      = startRd;
    acceptWrStart = startWr & ~startRd;
    acceptWr      = wrEn & ~startRd & ~startWr;
    acceptRead    = rdEn & ~startRd & ~startWr & ~wrEn;
  end

  always_comb begin
    addrByte = acceptWr & addrPhaseQ;
    dataByte = acceptWr & ~addrPhaseQ;
    advance  = dataByte | acceptRead;
    wrapHit  = advance && (ptrQ == LAST_ADDR);
  end

  always_comb begin
    cmd.capture   = acceptRd | wrapHit;
    cmd.loadTime  = dataByte && (ptrQ < CTRL_ADDR);
    cmd.storeCtrl = dataByte && (ptrQ == CTRL_ADDR);
    cmd.storeRam  = dataByte && (ptrQ > CTRL_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ       <= '0;
      addrPhaseQ <= 1'b0;
    end else begin
      if (acceptWrStart) addrPhaseQ <= 1'b1;
      else if (addrByte) addrPhaseQ <= 1'b0;

      if (addrByte)     ptrQ <= wrPtrBits;
      else if (advance) ptrQ <= ptrQ + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/tsnap_datapath.sv
module tsnap_datapath
  import tsnap_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 6,
  parameter int          SNAP_BYTES = 7,
  parameter logic [7:0]  CTRL_MASK  = 8'hB3,
  parameter int          OSF_BIT    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCmd_t                       cmd,
  input  logic [ADDR_W-1:0]            ptr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [SNAP_BYTES*DATA_W-1:0] timeNow,
  input  logic                         oscStopEvt,
  output logic [DATA_W-1:0]            rdData,
  output logic [DATA_W-1:0]            ctrlByte,
  output logic                         timeLoadEn,
  output logic [$clog2(SNAP_BYTES)-1:0] timeLoadIdx,
  output logic [DATA_W-1:0]            timeLoadData
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int RAM_BASE  = SNAP_BYTES + 1;
  localparam int RAM_DEPTH = DEPTH - RAM_BASE;
  localparam int IDX_W     = $clog2(SNAP_BYTES);
  localparam logic [DATA_W-1:0] OSF_MASK = DATA_W'(1) << OSF_BIT;
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0] snapQ [SNAP_BYTES];
  logic [DATA_W-1:0] ramQ  [RAM_DEPTH];
  logic [DATA_W-1:0] ctrlQ, ctrlNext;
  logic [ADDR_W-1:0] ramIdx;

  assign ramIdx = ptr - ADDR_W'(RAM_BASE);

  // Time copy: one register per field.
  for (genvar i = 0; i < SNAP_BYTES; i++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rstN)            snapQ[i] <= '0;
      else if (cmd.capture) snapQ[i] <= timeNow[i*DATA_W +: DATA_W];
    end
  end

  // General storage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < RAM_DEPTH; j++) ramQ[j] <= '0;
    end else if (cmd.storeRam) begin
      ramQ[ramIdx] <= wrData;
    end
  end

  // Control entry: reserved bits dropped, flag clear-only by write,
  // stop detect sets and wins.
  always_comb begin
    ctrlNext = ctrlQ;
    if (cmd.storeCtrl)
      ctrlNext = (wrData & KEEP_MASK & ~OSF_MASK) | (wrData & ctrlQ & OSF_MASK);
    if (oscStopEvt)
      ctrlNext = ctrlNext | OSF_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_comb begin
    if (ptr < ADDR_W'(SNAP_BYTES))       rdData = snapQ[ptr[IDX_W-1:0]];
    else if (ptr == ADDR_W'(SNAP_BYTES)) rdData = ctrlQ;
    else                                 rdData = ramQ[ramIdx];
  end

  assign ctrlByte     = ctrlQ;
  assign timeLoadEn   = cmd.loadTime;
  assign timeLoadIdx  = ptr[IDX_W-1:0];
  assign timeLoadData = wrData;

endmodule

// File: rtl/tsnap_regfile.sv
module tsnap_regfile
  import tsnap_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 6,
  parameter int          SNAP_BYTES = 7,
  parameter logic [7:0]  CTRL_MASK  = 8'hB3,
  parameter int          OSF_BIT    = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startWr,
  input  logic                          startRd,
  input  logic                          wrEn,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          rdEn,
  output logic [DATA_W-1:0]             rdData,
  input  logic [SNAP_BYTES*DATA_W-1:0]  timeNow,
  input  logic                          oscStopEvt,
  output logic                          timeLoadEn,
  output logic [$clog2(SNAP_BYTES)-1:0] timeLoadIdx,
  output logic [DATA_W-1:0]             timeLoadData
);

  dpCmd_t            cmd;
  logic [ADDR_W-1:0] ptrQ;
  logic              addrPhaseQ;
  logic [DATA_W-1:0] ctrlByte;

  tsnap_ctrl #(
    .ADDR_W    (ADDR_W),
    .SNAP_BYTES(SNAP_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startWr   (startWr),
    .startRd   (startRd),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrPtrBits (wrData[ADDR_W-1:0]),
    .cmd       (cmd),
    .ptrQ      (ptrQ),
    .addrPhaseQ(addrPhaseQ)
  );

  tsnap_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SNAP_BYTES(SNAP_BYTES),
    .CTRL_MASK (CTRL_MASK),
    .OSF_BIT   (OSF_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .ptr         (ptrQ),
    .wrData      (wrData),
    .timeNow     (timeNow),
    .oscStopEvt  (oscStopEvt),
    .rdData      (rdData),
    .ctrlByte    (ctrlByte),
    .timeLoadEn  (timeLoadEn),
    .timeLoadIdx (timeLoadIdx),
    .timeLoadData(timeLoadData)
  );

endmodule

// File: rtl/tsnap_checker.sv
module tsnap_checker #(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 6,
  parameter int          SNAP_BYTES = 7,
  parameter logic [7:0]  CTRL_MASK  = 8'hB3,
  parameter int          OSF_BIT    = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          startWr,
  input logic                          startRd,
  input logic                          wrEn,
  input logic [DATA_W-1:0]             wrData,
  input logic                          rdEn,
  input logic                          oscStopEvt,
  input logic                          timeLoadEn,
  input logic [$clog2(SNAP_BYTES)-1:0] timeLoadIdx,
  input logic [ADDR_W-1:0]             ptrQ,
  input logic                          addrPhaseQ,
  input logic [DATA_W-1:0]             ctrlByte
);

  localparam logic [DATA_W-1:0] RSVD = ~DATA_W'(CTRL_MASK);

  p_addr_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !startRd && !startWr && addrPhaseQ)
      |=> (ptrQ == $past(wrData[ADDR_W-1:0])) && !addrPhaseQ);

  p_read_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !startRd && !startWr && !wrEn)
      |=> ptrQ == ($past(ptrQ) + ADDR_W'(1)));

  p_load_only_clock_r5: assert property (@(posedge clk) disable iff (!rstN)
    timeLoadEn |-> wrEn && !addrPhaseQ && (ptrQ < ADDR_W'(SNAP_BYTES))
                   && (ADDR_W'(timeLoadIdx) == ptrQ));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte & RSVD) == '0);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    oscStopEvt |=> ctrlByte[OSF_BIT]);

  p_flag_no_write_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!oscStopEvt && !ctrlByte[OSF_BIT]) |=> !ctrlByte[OSF_BIT]);

  p_start_priority_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && !startRd) |=> addrPhaseQ && $stable(ptrQ));

endmodule

bind tsnap_regfile tsnap_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SNAP_BYTES(SNAP_BYTES),
  .CTRL_MASK (CTRL_MASK),
  .OSF_BIT   (OSF_BIT)
) u_chk (.*);

// File: tb/tsnap_regfile_bench.sv
module tsnap_regfile_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startWr = 1'b0, startRd = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [55:0] timeNow;
  logic        oscStopEvt = 1'b0;
  logic        timeLoadEn;
  logic [2:0]  timeLoadIdx;
  logic [7:0]  timeLoadData;

  int unsigned cyc = 0;
  int          vectors = 0;
  int          fails = 0;
  bit          done = 0;
  string       tag = "R8";

  // Behavioural reference state.
  int mem [64];
  int mPtr = 0;
  bit mAddr = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb
    for (int i = 0; i < 7; i++) timeNow[i*8 +: 8] = 8'(cyc * 7 + i * 13 + 1);

  tsnap_regfile u_tsnap_regfile (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .timeNow(timeNow), .oscStopEvt(oscStopEvt), .timeLoadEn(timeLoadEn),
    .timeLoadIdx(timeLoadIdx), .timeLoadData(timeLoadData)
  );

  task automatic checkVal(string t, int act, int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", t, act, expv, $time);
    end
  endtask

  // One cycle: drive, compare combinational outputs, advance model at edge.
  task automatic step(bit sW, bit sR, bit w, logic [7:0] d, bit r, bit o);
    bit expLoad, cap, adv;
    logic [55:0] tn;
    startWr = sW; startRd = sR; wrEn = w; wrData = d; rdEn = r; oscStopEvt = o;
    #1;
    checkVal({tag, " rdData (R9)"}, rdData, mem[mPtr]);
    expLoad = w && !sR && !sW && !mAddr && (mPtr < 7);
    checkVal({tag, " timeLoadEn (R5)"}, timeLoadEn, expLoad);
    if (expLoad) begin
      checkVal({tag, " timeLoadIdx (R5)"}, timeLoadIdx, mPtr);
      checkVal({tag, " timeLoadData (R5)"}, timeLoadData, d);
    end
    tn = timeNow;
    @(posedge clk);
    cap = 0; adv = 0;
    if (!rstN) begin
      foreach (mem[k]) mem[k] = 0;
      mPtr = 0; mAddr = 0;
    end else begin
      if (sR) cap = 1;
      else if (sW) mAddr = 1;
      else if (w) begin
        if (mAddr) begin mPtr = d & 63; mAddr = 0; end
        else begin
          if (mPtr == 7) mem[7] = (d & 8'h93) | (d & mem[7] & 8'h20);
          else if (mPtr > 7) mem[mPtr] = d;
          adv = 1;
        end
      end else if (r) adv = 1;
      if (o) mem[7] = mem[7] | 8'h20;
      if (adv) begin
        mPtr = (mPtr + 1) % 64;
        if (mPtr == 0) cap = 1;
      end
      if (cap) for (int i = 0; i < 7; i++) mem[i] = tn[i*8 +: 8];
    end
    #1;
  endtask

  task automatic idle(); step(0, 0, 0, 8'h00, 0, 0); endtask
  task automatic setPtr(int p); step(1, 0, 0, 0, 0, 0); step(0, 0, 1, 8'(p), 0, 0); endtask
  task automatic wr(int v); step(0, 0, 1, 8'(v), 0, 0); endtask
  task automatic rd(); step(0, 0, 0, 0, 1, 0); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    foreach (mem[k]) mem[k] = 0;
    @(posedge clk); #1;
    repeat (3) idle();
    rstN = 1'b1;
    // R8: every entry reads zero after reset, walked without a capture.
    tag = "R8";
    checkVal("R8 rdData at reset", rdData, 0);
    for (int i = 0; i < 64; i++) rd();

    // R1 / R2 / R3: storage through an explicit pointer, masked pointer byte.
    tag = "R1";
    setPtr(8'hC8);                      // R2: only low 6 bits -> 8
    for (int i = 0; i < 6; i++) wr(8'hA0 + i);
    tag = "R2";
    setPtr(8);
    checkVal("R2 pointer byte not stored", rdData, 8'hA0);
    tag = "R3";
    for (int i = 0; i < 6; i++) rd();

    // R5: clock writes go to the load port, the copy keeps its value.
    tag = "R5";
    step(0, 1, 0, 0, 0, 0);             // refresh copy
    setPtr(0);
    for (int i = 0; i < 7; i++) wr(8'h11 * (i + 1));
    setPtr(0);
    for (int i = 0; i < 7; i++) rd();

    // R6 / R7: control masking and flag rules.
    tag = "R6";
    setPtr(7); wr(8'hFF);
    setPtr(7); checkVal("R6 masked control", rdData, 8'h93);
    tag = "R7";
    step(0, 0, 0, 0, 0, 1);
    checkVal("R7 flag set by detect", rdData, 8'hB3);
    wr(8'hFF); setPtr(7);
    checkVal("R7 write 1 keeps flag", rdData, 8'hB3);
    wr(8'h00); setPtr(7);
    checkVal("R7 write 0 clears", rdData, 8'h00);
    step(0, 0, 1, 8'h00, 0, 1); setPtr(7);
    checkVal("R7 detect beats clear", rdData, 8'h20);

    // R4: wrap recapture by read and by write, and start-of-read capture.
    tag = "R4";
    setPtr(62); rd(); rd();
    for (int i = 0; i < 7; i++) rd();
    setPtr(63); wr(8'h5A);
    for (int i = 0; i < 3; i++) rd();
    step(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) rd();

    // R10: coinciding strobes, then a random sweep.
    tag = "R10";
    setPtr(20);
    step(1, 1, 1, 8'h33, 1, 0);         // startRd wins
    step(0, 0, 1, 8'h44, 1, 0);         // write wins over read
    setPtr(20);
    step(1, 0, 1, 8'h77, 0, 0);         // start wins; byte ignored
    step(0, 0, 1, 8'd20, 0, 0);
    rd(); rd();
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      step(sel < 4, sel >= 4 && sel < 7, sel >= 30 && sel < 65,
           8'($urandom), sel >= 55, sel >= 97);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule